// File: doc/BRIEF.md
# Audio Sample-Rate Detector

This block works out the audio sample rate of an incoming serial audio stream by timing its frame-select (word-clock) signal against a free-running reference clock. The reference frequency is a parameter. The nominal range for the reference is 13.3 MHz to 17 MHz. The block counts reference cycles across a fixed number of frame-select periods. It then matches that count against one acceptance window per supported rate. Each window is derived at elaboration time from the reference frequency, a ppm tolerance and a small quantisation slack.

The block reports a three-bit divider-range code for the clock generator that follows it. It also reports a lock flag and an error flag. Automatic detection is in force when the programmed rate selection holds the automatic value or when the decoder-mode strap is high. In any other case the programmed selection goes straight to the output and the detector sits idle.

Top module: `sample_rate_detect`

## Requirements
- R1: When automatic detection is not in force, `range_code_o` equals `rate_sel_i` in the same cycle. `locked_o` and `err_o` are low from the next clock edge on, and no measurement runs.
- R2: Automatic detection is in force when `rate_sel_i` is 3'b111 or when `mpeg_strap_i` is 1, whichever `rate_sel_i` is.
- R3: Each detected rate maps to a fixed code:
  - 48 kHz and 44.1 kHz give 3'b000.
  - 32 kHz gives 3'b001.
  - 24 kHz and 22.05 kHz give 3'b010.
  - 16 kHz gives 3'b011.
  - 12 kHz and 11.025 kHz give 3'b100.
  - 8 kHz gives 3'b101.
- R4: One measurement is the reference-cycle count over NFRAMES (16) frame-select periods, taken back to back. `locked_o` rises once two consecutive measurements fall in the same rate window. In automatic mode the output code changes only in the cycle where `locked_o` rises.
- R5: A measurement outside every window has three effects: `locked_o` goes low, `err_o` goes high, and the last locked code is kept on the output. `locked_o` and `err_o` are never high together.
- R6: If no frame-select rising edge arrives within twice the count expected at 8 kHz, `locked_o` drops and the code is kept.
- R7: A 96 kHz stream is never detected: it yields the error of R5. While locked in automatic mode, the code is never 3'b110 or 3'b111.
- R8: The first in-window measurement after an error clears `err_o`.
- R9: After reset `locked_o` and `err_o` are low, and the detected code is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_i | input | 1 | Frame-select signal, asynchronous to clk |
| rate_sel_i | input | 3 | Programmed range code; 3'b111 requests automatic detection |
| mpeg_strap_i | input | 1 | Mode strap forcing automatic detection |
| range_code_o | output | 3 | Divider-range code (detected or programmed) |
| locked_o | output | 1 | Detected rate confirmed by two matching measurements |
| err_o | output | 1 | Last measurement fell outside every window |

## Verification
The detector is fed all nine supported rates in one sweep. The sweep includes the pairs that share a code (44.1 and 48, 22.05 and 24, 11.025 and 12), so that adjacent windows must separate cleanly while the code stays put. A 96 kHz stream and a 40 kHz stream, both outside every window, show the error path keeps the last code, and a return to a legal rate shows recovery. A stopped frame-select shows the timeout against a short pause that must not drop lock. Toggling the strap and the programmed selection shows the switch between manual pass-through and detection.

// File: rtl/srd_pkg.sv
`timescale 1ns/1ps
package srd_pkg;

   localparam int N_RATES = 9;

   localparam logic [2:0] RANGE_32_48 = 3'b000;
   localparam logic [2:0] RANGE_26_32 = 3'b001;
   localparam logic [2:0] RANGE_20_26 = 3'b010;
   localparam logic [2:0] RANGE_14_20 = 3'b011;
   localparam logic [2:0] RANGE_10_14 = 3'b100;
   localparam logic [2:0] RANGE_8_10  = 3'b101;
   localparam logic [2:0] RANGE_96    = 3'b110;
   localparam logic [2:0] SEL_AUTO    = 3'b111;

   // Rates listed fastest first, so expected counts ascend with the index.
   function automatic longint rate_hz(input int idx);
      case (idx)
         0:       return 48000;
         1:       return 44100;
         2:       return 32000;
         3:       return 24000;
         4:       return 22050;
         5:       return 16000;
         6:       return 12000;
         7:       return 11025;
         default: return 8000;
      endcase
   endfunction

   function automatic logic [2:0] rate_code(input int idx);
      case (idx)
         0, 1:    return RANGE_32_48;
         2:       return RANGE_26_32;
         3, 4:    return RANGE_20_26;
         5:       return RANGE_14_20;
         6, 7:    return RANGE_10_14;
         default: return RANGE_8_10;
      endcase
   endfunction

   // Rounded reference-cycle count over nfr frame periods.
   function automatic longint exp_count(input longint ref_hz, input longint nfr, input int idx);
      return (2 * nfr * ref_hz / rate_hz(idx) + 1) / 2;
   endfunction

   function automatic longint win_lo(input longint ref_hz, input longint nfr,
                                     input longint tol_ppm, input longint slack, input int idx);
      longint e;
      e = exp_count(ref_hz, nfr, idx);
      return e - (e * tol_ppm) / 1000000 - slack;
   endfunction

   function automatic longint win_hi(input longint ref_hz, input longint nfr,
                                     input longint tol_ppm, input longint slack, input int idx);
      longint e;
      e = exp_count(ref_hz, nfr, idx);
      return e + (e * tol_ppm) / 1000000 + slack;
   endfunction

endpackage

// File: rtl/srd_fs_sync.sv
`timescale 1ns/1ps
module srd_fs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srd_fs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], d_i};
   end

   assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/srd_period_meter.sv
`timescale 1ns/1ps
module srd_period_meter #(
   parameter int     CNT_W   = 16,
   parameter int     NFRAMES = 16,
   parameter longint TMO_CYC = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             edge_i,
   output logic             meas_vld_o,
   output logic [CNT_W-1:0] meas_cnt_o,
   output logic             timeout_o
);
   localparam int               FR_W     = (NFRAMES > 1) ? $clog2(NFRAMES) : 1;
   localparam logic [FR_W-1:0]  FR_LAST  = FR_W'(NFRAMES - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(TMO_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   generate
      if (NFRAMES < 2) begin : g_bad_frames
         $error("srd_period_meter: NFRAMES must be at least 2");
      end
      if (TMO_CYC >= (longint'(1) << CNT_W)) begin : g_bad_width
         $error("srd_period_meter: CNT_W too narrow for timeout");
      end
   endgenerate

   logic             armed;
   logic [FR_W-1:0]  frm;
   logic [CNT_W-1:0] cyc, gap;
   logic [CNT_W-1:0] cyc_inc;

   assign cyc_inc = (cyc == CNT_MAX) ? cyc : cyc + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         frm        <= '0;
         cyc        <= '0;
         gap        <= '0;
         meas_vld_o <= 1'b0;
         meas_cnt_o <= '0;
         timeout_o  <= 1'b0;
      end else if (clr_i) begin
         armed      <= 1'b0;
         frm        <= '0;
         cyc        <= '0;
         gap        <= '0;
         meas_vld_o <= 1'b0;
         timeout_o  <= 1'b0;
      end else begin
         meas_vld_o <= 1'b0;
         timeout_o  <= 1'b0;
         if (edge_i) begin
            gap <= '0;
            if (!armed) begin
               armed <= 1'b1;
               cyc   <= '0;
               frm   <= '0;
            end else if (frm == FR_LAST) begin
               meas_vld_o <= 1'b1;
               meas_cnt_o <= cyc_inc;
               cyc        <= '0;
               frm        <= '0;
            end else begin
               frm <= frm + 1'b1;
               cyc <= cyc_inc;
            end
         end else if (armed) begin
            cyc <= cyc_inc;
            if (gap == GAP_LAST) begin
               timeout_o <= 1'b1;
               armed     <= 1'b0;
               gap       <= '0;
            end else begin
               gap <= gap + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/srd_classifier.sv
`timescale 1ns/1ps
module srd_classifier #(
   parameter int     CNT_W   = 16,
   parameter int     IDX_W   = 4,
   parameter longint REF_HZ  = 15000000,
   parameter int     NFRAMES = 16,
   parameter int     TOL_PPM = 200,
   parameter int     SLACK   = 2
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [2:0]       code_o
);
   import srd_pkg::*;

   logic [N_RATES-1:0] hit_v;

   generate
      for (genvar g = 0; g < N_RATES; g++) begin : g_win
         localparam longint LO_L = win_lo(REF_HZ, NFRAMES, TOL_PPM, SLACK, g);
         localparam longint HI_L = win_hi(REF_HZ, NFRAMES, TOL_PPM, SLACK, g);
         localparam logic [CNT_W-1:0] LO = CNT_W'(LO_L);
         localparam logic [CNT_W-1:0] HI = CNT_W'(HI_L);
         if (LO_L < 1 || HI_L >= (longint'(1) << CNT_W)) begin : g_bad_range
            $error("srd_classifier: window out of counter range");
         end
         if (g > 0) begin : g_order
            if (LO_L <= win_hi(REF_HZ, NFRAMES, TOL_PPM, SLACK, g - 1)) begin : g_overlap
               $error("srd_classifier: adjacent rate windows overlap");
            end
         end
         assign hit_v[g] = (cnt_i >= LO) && (cnt_i <= HI);
      end
   endgenerate

   always_comb begin
      idx_o  = '0;
      code_o = '0;
      for (int i = 0; i < N_RATES; i++) begin
         if (hit_v[i]) begin
            idx_o  = idx_o | IDX_W'(i);
            code_o = code_o | rate_code(i);
         end
      end
   end

   assign hit_o = |hit_v;
endmodule

// File: rtl/srd_lock_track.sv
`timescale 1ns/1ps
module srd_lock_track #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             meas_vld_i,
   input  logic             hit_i,
   input  logic [IDX_W-1:0] hit_idx_i,
   input  logic [2:0]       hit_code_i,
   input  logic             timeout_i,
   output logic [2:0]       code_o,
   output logic             locked_o,
   output logic             err_o
);
   logic             have_prev;
   logic [IDX_W-1:0] prev_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o    <= srd_pkg::RANGE_32_48;
         locked_o  <= 1'b0;
         err_o     <= 1'b0;
         have_prev <= 1'b0;
         prev_idx  <= '0;
      end else if (clr_i) begin
         locked_o  <= 1'b0;
         err_o     <= 1'b0;
         have_prev <= 1'b0;
      end else if (timeout_i) begin
         locked_o  <= 1'b0;
         have_prev <= 1'b0;
      end else if (meas_vld_i) begin
         if (hit_i) begin
            err_o <= 1'b0;
            if (have_prev && prev_idx == hit_idx_i) begin
               locked_o <= 1'b1;
               code_o   <= hit_code_i;
            end else begin
               locked_o  <= 1'b0;
               prev_idx  <= hit_idx_i;
               have_prev <= 1'b1;
            end
         end else begin
            locked_o  <= 1'b0;
            err_o     <= 1'b1;
            have_prev <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sample_rate_detect.sv
`timescale 1ns/1ps
module sample_rate_detect #(
   parameter int REF_HZ      = 15000000,
   parameter int NFRAMES     = 16,
   parameter int TOL_PPM     = 200,
   parameter int SLACK       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fs_i,
   input  logic [2:0] rate_sel_i,
   input  logic       mpeg_strap_i,
   output logic [2:0] range_code_o,
   output logic       locked_o,
   output logic       err_o
);
   import srd_pkg::*;

   localparam longint TMO_CYC = 2 * exp_count(REF_HZ, NFRAMES, N_RATES - 1);
   localparam int     CNT_W   = $clog2(TMO_CYC + 1) + 1;
   localparam int     IDX_W   = $clog2(N_RATES);

   generate
      if (TOL_PPM < 0 || TOL_PPM > 5000) begin : g_bad_tol
         $error("sample_rate_detect: TOL_PPM out of range");
      end
      if (SLACK < 0) begin : g_bad_slack
         $error("sample_rate_detect: SLACK must not be negative");
      end
   endgenerate

   logic             auto_en;
   logic             fs_rise;
   logic             meas_vld, timeout;
   logic [CNT_W-1:0] meas_cnt;
   logic             hit;
   logic [IDX_W-1:0] hit_idx;
   logic [2:0]       hit_code, det_code;

   assign auto_en = (rate_sel_i == SEL_AUTO) | mpeg_strap_i;

   srd_fs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (fs_i),
      .rise_o (fs_rise)
   );

   srd_period_meter #(.CNT_W(CNT_W), .NFRAMES(NFRAMES), .TMO_CYC(TMO_CYC)) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (~auto_en),
      .edge_i     (fs_rise),
      .meas_vld_o (meas_vld),
      .meas_cnt_o (meas_cnt),
      .timeout_o  (timeout)
   );

   srd_classifier #(.CNT_W(CNT_W), .IDX_W(IDX_W), .REF_HZ(REF_HZ), .NFRAMES(NFRAMES),
                    .TOL_PPM(TOL_PPM), .SLACK(SLACK)) u_class (
      .cnt_i  (meas_cnt),
      .hit_o  (hit),
      .idx_o  (hit_idx),
      .code_o (hit_code)
   );

   srd_lock_track #(.IDX_W(IDX_W)) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (~auto_en),
      .meas_vld_i (meas_vld),
      .hit_i      (hit),
      .hit_idx_i  (hit_idx),
      .hit_code_i (hit_code),
      .timeout_i  (timeout),
      .code_o     (det_code),
      .locked_o   (locked_o),
      .err_o      (err_o)
   );

   assign range_code_o = auto_en ? det_code : rate_sel_i;
endmodule

// File: rtl/srd_checker.sv
`timescale 1ns/1ps
module srd_checker #(
   parameter int REF_HZ  = 15000000,
   parameter int NFRAMES = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       fs_i,
   input logic [2:0] rate_sel_i,
   input logic       mpeg_strap_i,
   input logic [2:0] range_code_o,
   input logic       locked_o,
   input logic       err_o
);
   localparam longint TMO_CYC = 2 * srd_pkg::exp_count(REF_HZ, NFRAMES, srd_pkg::N_RATES - 1);
   localparam int     GAP_LIM = int'(TMO_CYC) + 8;

   logic auto_en;
   logic fs_q;
   int   gap;

   assign auto_en = (rate_sel_i == 3'b111) | mpeg_strap_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q <= 1'b0;
         gap  <= 0;
      end else begin
         fs_q <= fs_i;
         if (fs_i && !fs_q)     gap <= 0;
         else if (gap < GAP_LIM + 1) gap <= gap + 1;
      end
   end

   assert_manual_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> (!locked_o && !err_o));

   assert_code_on_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && $past(auto_en) && !$stable(range_code_o)) |-> $rose(locked_o));

   assert_lock_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(locked_o && err_o));

   assert_timeout_unlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gap > GAP_LIM) |-> !locked_o);

   assert_no_high_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && locked_o) |-> (range_code_o <= 3'd5));
endmodule

bind sample_rate_detect srd_checker #(.REF_HZ(REF_HZ), .NFRAMES(NFRAMES)) u_srd_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fs_i         (fs_i),
   .rate_sel_i   (rate_sel_i),
   .mpeg_strap_i (mpeg_strap_i),
   .range_code_o (range_code_o),
   .locked_o     (locked_o),
   .err_o        (err_o)
);

// File: tb/sample_rate_detect_tb.sv
`timescale 1ns/1ps
module sample_rate_detect_tb;
   localparam int REF_HZ = 1536000;
   localparam int NFR    = 16;
   localparam int TMO    = 2 * NFR * REF_HZ / 8000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fs = 1'b0;
   logic [2:0] rate_sel = 3'b000;
   logic       strap = 1'b0;
   logic [2:0] code;
   logic       locked, err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sample_rate_detect #(.REF_HZ(REF_HZ), .NFRAMES(NFR)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .fs_i         (fs),
      .rate_sel_i   (rate_sel),
      .mpeg_strap_i (strap),
      .range_code_o (code),
      .locked_o     (locked),
      .err_o        (err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_rate(input real rate, input int periods);
      real half;
      half = 2.5 * REF_HZ / rate;
      for (int p = 0; p < periods; p++) begin
         fs = 1'b1;
         #(half);
         fs = 1'b0;
         #(half);
      end
      @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "locked after reset", int'(locked), 0);
      chk("R9", "err after reset", int'(err), 0);
      rate_sel = 3'b111;
      @(negedge clk);
      chk("R9", "detected code after reset", int'(code), 0);
   endtask

   task automatic t_manual;
      rate_sel = 3'b000;
      strap    = 1'b0;
      for (int c = 0; c < 7; c++) begin
         rate_sel = 3'(c);
         run_rate(48000.0, 3);
         chk("R1", "manual pass-through code", int'(code), c);
         chk("R1", "manual locked low", int'(locked), 0);
      end
   endtask

   task automatic t_auto_sweep;
      real rt [9] = '{48000.0, 44100.0, 32000.0, 24000.0, 22050.0,
                      16000.0, 12000.0, 11025.0, 8000.0};
      int  cd [9] = '{0, 0, 1, 2, 2, 3, 4, 4, 5};
      rate_sel = 3'b111;
      for (int k = 0; k < 9; k++) begin
         run_rate(rt[k], 56);
         chk("R4", $sformatf("locked at %0.0f Hz", rt[k]), int'(locked), 1);
         chk("R3", $sformatf("code at %0.0f Hz", rt[k]), int'(code), cd[k]);
         chk("R5", $sformatf("err at %0.0f Hz", rt[k]), int'(err), 0);
      end
   endtask

   task automatic t_out_of_range;
      rate_sel = 3'b111;
      run_rate(16000.0, 56);
      chk("R4", "locked at 16k before error", int'(locked), 1);
      run_rate(96000.0, 60);
      chk("R7", "96k raises err", int'(err), 1);
      chk("R7", "96k drops lock", int'(locked), 0);
      chk("R5", "code kept across 96k", int'(code), 3);
      run_rate(40000.0, 60);
      chk("R5", "40k raises err", int'(err), 1);
      chk("R5", "code kept across 40k", int'(code), 3);
      run_rate(16000.0, 56);
      chk("R8", "err cleared on legal rate", int'(err), 0);
      chk("R8", "relock after error", int'(locked), 1);
   endtask

   task automatic t_timeout;
      rate_sel = 3'b111;
      run_rate(24000.0, 56);
      chk("R6", "locked before pause", int'(locked), 1);
      repeat (100) @(negedge clk);
      chk("R6", "short pause keeps lock", int'(locked), 1);
      repeat (TMO + 40) @(negedge clk);
      chk("R6", "lock dropped on timeout", int'(locked), 0);
      chk("R6", "code kept after timeout", int'(code), 2);
   endtask

   task automatic t_strap;
      rate_sel = 3'b010;
      strap    = 1'b1;
      run_rate(16000.0, 56);
      chk("R2", "strap enables detection code", int'(code), 3);
      chk("R2", "strap enables detection lock", int'(locked), 1);
      strap = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", "strap off returns manual code", int'(code), 2);
      chk("R1", "strap off clears lock", int'(locked), 0);
   endtask

   task automatic t_disable;
      rate_sel = 3'b111;
      run_rate(32000.0, 56);
      chk("R3", "32k code before disable", int'(code), 1);
      rate_sel = 3'b101;
      repeat (2) @(negedge clk);
      chk("R1", "manual code after disable", int'(code), 5);
      chk("R1", "lock cleared after disable", int'(locked), 0);
      chk("R1", "err low after disable", int'(err), 0);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      t_reset();
      t_manual();
      t_auto_sweep();
      t_out_of_range();
      t_timeout();
      t_strap();
      t_disable();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual hung expected completion");
         summary();
         $finish;
      end
   end
endmodule